// File: doc/BRIEF.md
# Four-Lane Word Serializer and Deserializer with Bit Slip

This block converts parallel words to a one-bit serial stream and back again. Everything runs on one clock at the serial bit rate. A divide-by-word-width phase counter on each side takes the place of a slower parallel clock.

On the transmit side, the incoming word is registered once per word period. It is then loaded into a shift chain through a multiplexer in front of each stage, and shifted out least significant bit first. On the receive side, incoming bits are shifted into a chain, and every word period the chain is copied into a parallel output register, with a one-cycle valid strobe.

The receiver cannot know where a word starts. A looped-back link can therefore deliver words rotated by one bit. A bit-slip input moves the receive capture point later by one serial cycle, which lets the surrounding logic bring the words back into alignment.

Top module: `serdes_link_pair`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears every stage. After that edge, `ser_out`, `par_out` and `par_valid` are all zero.
- R2: Counting clock edges from reset release, `tx_take` is high in the cycle after edge 3, edge 7, edge 11 and so on. That is one cycle in every WIDTH cycles. `par_in` is registered at the edge that ends each such cycle.
- R3: A word registered at edge E is loaded into the shift chain at edge E+1. After edges E+1, E+2, E+3 and E+4, `ser_out` carries bit 0, bit 1, bit 2 and bit 3 of that word, in that order (least significant bit first).
- R4: A value on `par_in` in any cycle where `tx_take` is low has no effect on `ser_out`.
- R5: The receiver shifts `ser_in` in at every edge. At a capture edge, `par_out` takes the last WIDTH bits received, with the earliest in bit 0 and the bit of the capture edge itself in bit WIDTH-1. `par_valid` is high for exactly the one cycle after each capture.
- R6: When `slip` is high in a cycle, no capture happens at the following edge, and every later capture moves one cycle later.
- R7: With `ser_out` looped to `ser_in` and `par_in` held at a constant word w after reset, with no slip, the captured word is w rotated up by one: `{w[2:0], w[3]}`. One slip makes the captured word equal w.
- R8: WIDTH slips bring the capture point back to its original phase.
- R9: `par_out` does not change in any cycle other than a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | WIDTH | Parallel word to transmit |
| tx_take | output | 1 | High in the cycle whose closing edge registers `par_in` |
| ser_out | output | 1 | Serial transmit bit |
| ser_in | input | 1 | Serial receive bit |
| slip | input | 1 | Delays the receive capture point by one cycle |
| par_out | output | WIDTH | Recovered parallel word |
| par_valid | output | 1 | One-cycle strobe for each capture |

## Verification
The bench builds the block with WIDTH = 4. At that width, each word period is only four cycles long, so a few hundred cycles cover every transmit phase and every receive capture phase many times. The full cycle of four slips back to the starting phase also fits in a short directed sequence. The same width makes the one-bit rotation of a looped-back link appear, without slip, as a fixed and easily predicted value.

// File: rtl/serdes_pkg.sv
package serdes_pkg;
  typedef enum logic {
    SEL_SHIFT = 1'b0,
    SEL_LOAD  = 1'b1
  } stage_sel_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/word_phase_ctr.sv
module word_phase_ctr #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic at_first,
  output logic at_last
);
  localparam int unsigned CW = serdes_pkg::cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!hold) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_first = (cnt_q == '0);
  assign at_last  = (cnt_q == LAST);
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  output logic             take,
  output logic             ser_out
);
  import serdes_pkg::*;

  logic             at_first;
  logic             at_last;
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;
  stage_sel_e       sel;

  word_phase_ctr #(.WIDTH(WIDTH)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .hold     (1'b0),
    .at_first (at_first),
    .at_last  (at_last)
  );

  assign sel = at_first ? SEL_LOAD : SEL_SHIFT;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (at_last) word_q <= par_in;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == WIDTH - 1) begin : g_tail
      assign chain_d[i] = (sel == SEL_LOAD) ? word_q[i] : 1'b0;
    end else begin : g_mid
      assign chain_d[i] = (sel == SEL_LOAD) ? word_q[i] : chain_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= chain_d;
  end

  assign take    = at_last;
  assign ser_out = chain_q[0];
endmodule

// File: rtl/des_rx.sv
module des_rx #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             slip,
  output logic [WIDTH-1:0] par_out,
  output logic             par_valid
);
  logic             at_first;
  logic             at_last;
  logic [WIDTH-1:0] shreg_q;
  logic [WIDTH-1:0] shreg_d;

  word_phase_ctr #(.WIDTH(WIDTH)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .hold     (slip),
    .at_first (at_first),
    .at_last  (at_last)
  );

  if (WIDTH > 1) begin : g_shift
    assign shreg_d = {ser_in, shreg_q[WIDTH-1:1]};
  end else begin : g_one
    assign shreg_d = ser_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q   <= '0;
      par_out   <= '0;
      par_valid <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      if (at_last && !slip) begin
        par_out   <= shreg_d;
        par_valid <= 1'b1;
      end else begin
        par_valid <= 1'b0;
      end
    end
  end

  logic unused_first;
  assign unused_first = at_first;
endmodule

// File: rtl/serdes_link_pair.sv
module serdes_link_pair #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  output logic             tx_take,
  output logic             ser_out,
  input  logic             ser_in,
  input  logic             slip,
  output logic [WIDTH-1:0] par_out,
  output logic             par_valid
);
  ser_tx #(.WIDTH(WIDTH)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .par_in  (par_in),
    .take    (tx_take),
    .ser_out (ser_out)
  );

  des_rx #(.WIDTH(WIDTH)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .ser_in    (ser_in),
    .slip      (slip),
    .par_out   (par_out),
    .par_valid (par_valid)
  );
endmodule

// File: rtl/serdes_link_chk.sv
module serdes_link_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] par_in,
  input logic             tx_take,
  input logic             ser_out,
  input logic             slip,
  input logic [WIDTH-1:0] par_out,
  input logic             par_valid
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ser_out == 1'b0 && !par_valid && par_out == '0)); // R1

  AST_TAKE_SPACED: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> !tx_take); // R2

  AST_FIRST_BIT_OUT: assert property (@(posedge clk) disable iff (rst)
    $past(tx_take, 2) |-> (ser_out == $past(par_in[0], 2))); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    par_valid |=> !par_valid); // R5

  AST_SLIP_SKIPS: assert property (@(posedge clk) disable iff (rst)
    slip |=> !par_valid); // R6

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !par_valid |-> $stable(par_out)); // R9
endmodule

bind serdes_link_pair serdes_link_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .par_in    (par_in),
  .tx_take   (tx_take),
  .ser_out   (ser_out),
  .slip      (slip),
  .par_out   (par_out),
  .par_valid (par_valid)
);

// File: tb/serdes_link_pair_bench.sv
module serdes_link_pair_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         drv_bit = 1'b0;
  logic         loop_en = 1'b0;
  logic         slip = 1'b0;
  logic         tx_take, ser_out, par_valid;
  logic [W-1:0] par_out;
  logic         ser_in;

  assign ser_in = loop_en ? ser_out : drv_bit;

  always #2 clk = ~clk;

  serdes_link_pair #(.WIDTH(W)) u_serdes_link_pair (
    .clk(clk), .rst(rst), .par_in(par_in), .tx_take(tx_take),
    .ser_out(ser_out), .ser_in(ser_in), .slip(slip),
    .par_out(par_out), .par_valid(par_valid)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int          cyc = 0;
  logic [15:0] sched;
  logic [W-1:0] m_hist, m_word;
  logic        m_valid;
  int          m_phase;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Expected behaviour after the coming edge, from the requirements.
  task automatic model_edge(input logic [W-1:0] p, input logic s);
    logic x;
    x = ser_in;
    if (cyc % W == W - 1)                               // R2
      for (int j = 0; j < W; j++) sched[(cyc + 2 + j) % 16] = p[j]; // R3
    m_valid = 1'b0;
    if (!s) begin                                       // R6
      if (m_phase == W - 1) begin
        m_word  = {x, m_hist[W-1:1]};                   // R5
        m_valid = 1'b1;
        m_phase = 0;
      end else m_phase++;
    end
    m_hist = {x, m_hist[W-1:1]};
  endtask

  task automatic step(input logic [W-1:0] p, input logic d, input logic s, input logic lp);
    @(negedge clk);
    chk(tx_take == (cyc % W == W - 1), "R2 tx_take", tx_take, cyc % W == W - 1);
    chk(ser_out == sched[cyc % 16], "R3/R4 ser_out", ser_out, sched[cyc % 16]);
    chk(par_valid == m_valid, "R5 par_valid", par_valid, m_valid);
    chk(par_out == m_word, "R5/R9 par_out", par_out, m_word);
    par_in = p; drv_bit = d; slip = s; loop_en = lp;
    #0;
    model_edge(p, s);
    cyc++;
  endtask

  task automatic do_reset(input logic [W-1:0] p, input logic lp);
    rst = 1'b1; slip = 1'b0; par_in = p; loop_en = lp;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0 && par_valid == 1'b0 && par_out == '0, "R1 reset state",
        {ser_out, par_valid, par_out}, 0);
    rst = 1'b0;
    sched = '0; m_hist = '0; m_word = '0; m_valid = 1'b0; m_phase = 0; cyc = 0;
    #0;
    model_edge(p, 1'b0);
    cyc = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    do_reset('0, 1'b0);
    // Random traffic: par_in changes every cycle, only taken words may appear (R4).
    for (int i = 0; i < 800; i++)
      step(W'($urandom), 1'($urandom), ($urandom % 9 == 0), (i >= 400));

    // Looped link, constant word, no slip: rotated by one (R7).
    do_reset(4'b0011, 1'b1);
    for (int i = 0; i < 24; i++) step(4'b0011, 1'b0, 1'b0, 1'b1);
    chk(par_out == 4'b0110, "R7 rotated word", par_out, 4'b0110);
    step(4'b0011, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(4'b0011, 1'b0, 1'b0, 1'b1);
    chk(par_out == 4'b0011, "R7 aligned after one slip", par_out, 4'b0011);

    // Four more slips return to the aligned phase (R8).
    for (int k = 0; k < W; k++) begin
      step(4'b0011, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 5; i++) step(4'b0011, 1'b0, 1'b0, 1'b1);
    end
    for (int i = 0; i < 12; i++) step(4'b0011, 1'b0, 1'b0, 1'b1);
    chk(par_out == 4'b0011, "R8 phase after four slips", par_out, 4'b0011);

    // Back-to-back slips: no capture while slip is held (R6).
    step(4'b0011, 1'b0, 1'b1, 1'b1);
    step(4'b0011, 1'b0, 1'b1, 1'b1);
    step(4'b0011, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk(par_valid == 1'b0, "R6 no strobe after slip", par_valid, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule